// File: doc/BRIEF.md
# Speculative Checkpoint Commit Buffer

This block holds the architectural side effects of a speculatively executed code region until software decides whether the region was good. Register writes go to a 64-entry working integer register file, and every working register has a shadow copy holding the last committed value. Stores issued inside the region are held in an ordered store queue and do not reach memory until the region is committed.

A commit strobe copies the whole working file into the shadow in one cycle. It then releases the queued stores to the memory write port one per cycle, oldest first. A rollback strobe, used when the region raises an exception, brings every working register back to its shadow value in the next cycle and throws away every store that has not yet been committed. Loads can look into the queue and receive the youngest queued data for their address. This keeps speculative code consistent with its own earlier stores.

Top module: `spec_ckpt_buffer`

## Requirements
- R1: After reset all working and shadow registers read as zero, the queue is empty, `sb_full` and `mem_we` are 0 and `ld_hit` is 0.
- R2: `rf_rdata` combinationally returns the working value of register `rf_raddr`. A write on `rf_we` is visible from the cycle after its clock edge.
- R3: On a commit, all working registers are copied into the shadow at the same clock edge. A register write presented in that same cycle lands in the working file only and is not part of the committed state.
- R4: Accepted stores never appear on the memory port before a commit. After a commit, every store queued before it is written out with `mem_we` high. They leave one per cycle in issue order, the first in the cycle right after the commit edge.
- R5: A rollback makes the working file equal to the shadow from the cycle after the strobe, and reads before that edge still return working values. A register write in the rollback cycle is lost. When commit and rollback are both high, only the rollback happens.
- R6: The queue holds 16 stores, and `sb_full` is 1 while it holds 16. A store offered while `sb_full` is 1 is dropped.
- R7: A rollback discards every uncommitted store, including one offered in the rollback cycle. Discarded stores never reach memory and no longer match loads.
- R8: `ld_hit` is 1 when any queued store has address `ld_addr`, and `ld_data` is then the data of the youngest such store. Stores that are committed but not yet drained are included. Otherwise `ld_hit` is 0.
- R9: A store offered in the same cycle as a commit belongs to the next region. That commit does not drain it, and a later rollback discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_we | input | 1 | Working register write enable |
| rf_waddr | input | 6 | Working register write index |
| rf_wdata | input | 32 | Working register write data |
| rf_raddr | input | 6 | Register read index |
| rf_rdata | output | 32 | Working value of the read register |
| st_valid | input | 1 | Speculative store offered |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| sb_full | output | 1 | Queue holds its maximum number of stores |
| ld_addr | input | 16 | Load address to look up in the queue |
| ld_hit | output | 1 | A queued store matches `ld_addr` |
| ld_data | output | 32 | Data of the youngest matching store |
| commit | input | 1 | End the region successfully |
| rollback | input | 1 | Abandon the region |
| mem_we | output | 1 | Committed store written to memory this cycle |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The main function is tried with three kinds of region. The first is one that writes registers and is rolled back, which separates a correct restore from a design that keeps working values. The second is one that queues repeated stores to the same address and commits, which shows whether drain order and youngest-match forwarding follow issue order. The third is one that fills the queue and offers one store too many. Directed patterns then set commit, rollback, register writes and stores against each other in the same cycle, so that each same-cycle priority rule is tested on its own.

// File: rtl/spec_ckpt_pkg.sv
package spec_ckpt_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE     = 2'd0,
    CTL_COMMIT   = 2'd1,
    CTL_ROLLBACK = 2'd2
  } ctl_e;

  // Rollback wins over commit when both strobes arrive together.
  function automatic ctl_e resolve_ctl(input logic do_commit, input logic do_abort);
    if (do_abort)  return CTL_ROLLBACK;
    if (do_commit) return CTL_COMMIT;
    return CTL_IDLE;
  endfunction

  // Occupancy after one cycle of optional enqueue and dequeue.
  function automatic int unsigned next_count(input int unsigned cur,
                                             input logic enq, input logic deq);
    return cur + (enq ? 1 : 0) - (deq ? 1 : 0);
  endfunction

endpackage

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
  parameter int NREG = 64,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          snap,
  input  logic          restore
);

  logic [DW-1:0] work_q   [NREG];
  logic [DW-1:0] shadow_q [NREG];

  assign rdata = work_q[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        work_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else if (restore) begin
      for (int i = 0; i < NREG; i++) work_q[i] <= shadow_q[i];
    end else begin
      if (snap) begin
        for (int i = 0; i < NREG; i++) shadow_q[i] <= work_q[i];
      end
      if (we) work_q[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/ckpt_store_queue.sv
module ckpt_store_queue
  import spec_ckpt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          commit_i,
  input  logic          rollback_i,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          full,
  output logic          push_ok,
  output logic          pop,
  output logic [AW-1:0] drain_addr,
  output logic [DW-1:0] drain_data
);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;   // all queued entries
  logic [CW-1:0] ccnt_q;  // committed entries at the head, still to drain

  assign full       = (cnt_q == CW'(DEPTH));
  assign pop        = (ccnt_q != '0);
  assign push_ok    = push_req && !full && !rollback_i;
  assign drain_addr = addr_q[head_q];
  assign drain_data = data_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ccnt_q <= '0;
    end else begin
      head_q <= head_q + PW'(pop);
      if (rollback_i) begin
        cnt_q  <= ccnt_q - CW'(pop);
        ccnt_q <= ccnt_q - CW'(pop);
        tail_q <= head_q + PW'(ccnt_q);
      end else begin
        cnt_q  <= CW'(next_count(int'(cnt_q), push_ok, pop));
        ccnt_q <= commit_i ? (cnt_q - CW'(pop)) : (ccnt_q - CW'(pop));
        tail_q <= tail_q + PW'(push_ok);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  // Walk from oldest to youngest so the last match wins.
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt_q) && (addr_q[head_q + PW'(i)] == ld_addr)) begin
        ld_hit  = 1'b1;
        ld_data = data_q[head_q + PW'(i)];
      end
    end
  end

endmodule

// File: rtl/spec_ckpt_buffer.sv
module spec_ckpt_buffer
  import spec_ckpt_pkg::*;
#(
  parameter int NREG     = 64,
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int SB_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rf_we,
  input  logic [$clog2(NREG)-1:0] rf_waddr,
  input  logic [DW-1:0]           rf_wdata,
  input  logic [$clog2(NREG)-1:0] rf_raddr,
  output logic [DW-1:0]           rf_rdata,
  input  logic                    st_valid,
  input  logic [AW-1:0]           st_addr,
  input  logic [DW-1:0]           st_data,
  output logic                    sb_full,
  input  logic [AW-1:0]           ld_addr,
  output logic                    ld_hit,
  output logic [DW-1:0]           ld_data,
  input  logic                    commit,
  input  logic                    rollback,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata
);

  ctl_e ctl;
  logic commit_eff;
  logic rollback_eff;
  logic st_accept;
  logic drain_fire;

  assign ctl          = resolve_ctl(commit, rollback);
  assign commit_eff   = (ctl == CTL_COMMIT);
  assign rollback_eff = (ctl == CTL_ROLLBACK);
  assign mem_we       = drain_fire;

  ckpt_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr   (rf_raddr),
    .rdata   (rf_rdata),
    .snap    (commit_eff),
    .restore (rollback_eff)
  );

  ckpt_store_queue #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (st_valid),
    .push_addr  (st_addr),
    .push_data  (st_data),
    .commit_i   (commit_eff),
    .rollback_i (rollback_eff),
    .ld_addr    (ld_addr),
    .ld_hit     (ld_hit),
    .ld_data    (ld_data),
    .full       (sb_full),
    .push_ok    (st_accept),
    .pop        (drain_fire),
    .drain_addr (mem_addr),
    .drain_data (mem_wdata)
  );

endmodule

// File: rtl/spec_ckpt_buffer_chk.sv
module spec_ckpt_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic commit,
  input logic rollback,
  input logic commit_eff,
  input logic rollback_eff,
  input logic st_valid,
  input logic st_accept,
  input logic sb_full,
  input logic mem_we
);

  logic seen_commit;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_commit <= 1'b0;
    else if (commit_eff) seen_commit <= 1'b1;
  end

  // R4: nothing is written to memory before the first commit
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> seen_commit);

  // R6: a store offered while full is not taken
  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && sb_full) |-> !st_accept);

  // R6: the queue only becomes full right after accepting a store
  p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_full) |-> $past(st_accept));

  // R5: rollback has priority over commit
  p_rbwins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rollback) |-> (rollback_eff && !commit_eff));

  // R7: a rollback with nothing committed pending leaves the queue not full
  p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback_eff && !mem_we) |=> !sb_full);

endmodule

bind spec_ckpt_buffer spec_ckpt_buffer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit       (commit),
  .rollback     (rollback),
  .commit_eff   (commit_eff),
  .rollback_eff (rollback_eff),
  .st_valid     (st_valid),
  .st_accept    (st_accept),
  .sb_full      (sb_full),
  .mem_we       (mem_we)
);

// File: tb/spec_ckpt_buffer_test.sv
module spec_ckpt_buffer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_we = 1'b0;
  logic [5:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic [5:0]  rf_raddr = '0;
  logic [31:0] rf_rdata;
  logic        st_valid = 1'b0;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        sb_full;
  logic [15:0] ld_addr = '0;
  logic        ld_hit;
  logic [31:0] ld_data;
  logic        commit = 1'b0;
  logic        rollback = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;

  int total = 0;
  int bad = 0;
  int log_n = 0;
  int mchk = 0;
  logic [15:0] log_a [64];
  logic [31:0] log_d [64];

  always #10 clk = ~clk;  // 50 MHz

  spec_ckpt_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .sb_full(sb_full),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .commit(commit), .rollback(rollback),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // memory-side monitor: one entry per cycle with mem_we high
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (log_n < 64) begin
        log_a[log_n] = mem_addr;
        log_d[log_n] = mem_wdata;
      end
      log_n = log_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic store(input logic [15:0] a, input logic [31:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    while (mem_we) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_rollback();
    rollback = 1'b1;
    @(negedge clk);
    rollback = 1'b0;
  endtask

  task automatic reg_read(input string tag, input logic [5:0] a, input logic [31:0] d);
    rf_raddr = a; #1;
    check(tag, rf_rdata, d);
  endtask

  task automatic load(input string tag, input logic [15:0] a, input logic h, input logic [31:0] d);
    ld_addr = a; #1;
    check(tag, {31'd0, ld_hit}, {31'd0, h});
    if (h) check(tag, ld_data, d);
  endtask

  // op: 1 write, 2 read, 3 store, 4 commit, 5 rollback, 6 load hit,
  //     7 load miss, 8 next memory write, 9 memory write count
  // fields: {op[4], req[4], addr[16], data[32]}
  localparam int NV = 24;
  localparam logic [55:0] VEC [NV] = '{
    {4'd1, 4'd2, 16'h0001, 32'h0000_0011},  // R2
    {4'd1, 4'd2, 16'h0002, 32'h0000_0022},
    {4'd2, 4'd2, 16'h0001, 32'h0000_0011},  // R2 read back
    {4'd4, 4'd3, 16'h0000, 32'h0},          // R3 commit
    {4'd1, 4'd5, 16'h0001, 32'h0000_00AA},
    {4'd2, 4'd2, 16'h0001, 32'h0000_00AA},
    {4'd5, 4'd5, 16'h0000, 32'h0},          // R5 rollback
    {4'd2, 4'd5, 16'h0001, 32'h0000_0011},
    {4'd2, 4'd3, 16'h0002, 32'h0000_0022},
    {4'd3, 4'd4, 16'h0100, 32'h0000_0005},  // R4 stores
    {4'd3, 4'd4, 16'h0104, 32'h0000_0006},
    {4'd3, 4'd4, 16'h0100, 32'h0000_0007},
    {4'd6, 4'd8, 16'h0100, 32'h0000_0007},  // R8 youngest
    {4'd6, 4'd8, 16'h0104, 32'h0000_0006},
    {4'd9, 4'd4, 16'h0000, 32'd0},          // R4 nothing before commit
    {4'd4, 4'd4, 16'h0000, 32'h0},
    {4'd8, 4'd4, 16'h0100, 32'h0000_0005},  // R4 issue order
    {4'd8, 4'd4, 16'h0104, 32'h0000_0006},
    {4'd8, 4'd4, 16'h0100, 32'h0000_0007},
    {4'd7, 4'd8, 16'h0100, 32'h0},
    {4'd3, 4'd7, 16'h0200, 32'h0000_0009},  // R7
    {4'd5, 4'd7, 16'h0000, 32'h0},
    {4'd7, 4'd7, 16'h0200, 32'h0},
    {4'd9, 4'd7, 16'h0000, 32'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sb_full", {31'd0, sb_full}, 32'd0);
    check("R1 mem_we", {31'd0, mem_we}, 32'd0);
    reg_read("R1 reg0", 6'd0, 32'd0);
    reg_read("R1 reg63", 6'd63, 32'd0);
    load("R1 no hit", 16'h0000, 1'b0, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [3:0]  rq;
      logic [15:0] va;
      logic [31:0] vd;
      string tag;
      {op, rq, va, vd} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        4'd1: reg_write(va[5:0], vd);
        4'd2: reg_read(tag, va[5:0], vd);
        4'd3: store(va, vd);
        4'd4: do_commit();
        4'd5: do_rollback();
        4'd6: load(tag, va, 1'b1, vd);
        4'd7: load(tag, va, 1'b0, vd);
        4'd8: begin
          check(tag, {16'd0, log_a[mchk]}, {16'd0, va});
          check(tag, log_d[mchk], vd);
          mchk++;
        end
        default: check(tag, log_n, vd);
      endcase
    end

    // R5 rollback timing: old value until the edge, shadow after it
    reg_write(6'd3, 32'h33);
    rollback = 1'b1;
    reg_read("R5 before edge", 6'd3, 32'h33);
    @(negedge clk);
    rollback = 1'b0;
    reg_read("R5 after edge", 6'd3, 32'h0);

    // R3 write in the commit cycle is not committed
    rf_we = 1'b1; rf_waddr = 6'd7; rf_wdata = 32'h70; commit = 1'b1;
    @(negedge clk);
    rf_we = 1'b0; commit = 1'b0;
    reg_read("R3 write visible", 6'd7, 32'h70);
    do_rollback();
    reg_read("R3 write not in shadow", 6'd7, 32'h0);
    reg_read("R3 older state kept", 6'd1, 32'h11);

    // R5 commit and rollback together: rollback only
    reg_write(6'd5, 32'h55);
    store(16'h0300, 32'h1);
    commit = 1'b1; rollback = 1'b1;
    @(negedge clk);
    commit = 1'b0; rollback = 1'b0;
    repeat (3) @(negedge clk);
    reg_read("R5 both strobes reg", 6'd5, 32'h0);
    check("R5 both strobes no drain", log_n, 32'd3);
    load("R5 both strobes store gone", 16'h0300, 1'b0, 32'd0);

    // R9 store in the commit cycle stays speculative
    st_valid = 1'b1; st_addr = 16'h0400; st_data = 32'h44; commit = 1'b1;
    @(negedge clk);
    st_valid = 1'b0; commit = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 not drained", log_n, 32'd3);
    load("R9 still queued", 16'h0400, 1'b1, 32'h44);
    do_rollback();
    load("R9 discarded", 16'h0400, 1'b0, 32'd0);

    // R6 fill to 16, offer one more
    for (int i = 0; i < 16; i++) store(16'h0500 + 16'(i), 32'(i + 1));
    check("R6 full at 16", {31'd0, sb_full}, 32'd1);
    store(16'h0999, 32'hDEAD);
    load("R6 extra dropped", 16'h0999, 1'b0, 32'd0);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check("R4 drain starts next cycle", {31'd0, mem_we}, 32'd1);
    load("R8 committed entry forwards", 16'h050F, 1'b1, 32'd16);
    while (mem_we) @(negedge clk);
    check("R6 drained count", log_n, 32'd19);
    for (int i = 0; i < 16; i++) begin
      check("R4 full drain addr", {16'd0, log_a[3 + i]}, {16'd0, 16'h0500 + 16'(i)});
      check("R4 full drain data", log_d[3 + i], 32'(i + 1));
    end
    check("R6 not full after drain", {31'd0, sb_full}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule